// File: doc/BRIEF.md
# Block Move, Search and Port Stream Engine

This engine moves bytes between memory locations, scans memory for a byte value, and streams bytes between memory and a single I/O port. It keeps three working registers: a source/memory pointer, a destination pointer and a 16-bit count. It also keeps a search key and a port number. A command code picks the operation, the direction in which the pointers move, and whether the engine runs one step or repeats until its stop rule is met. No instruction decoding takes place.

Each byte takes two clock cycles. In the first cycle the engine issues a read to memory or to the port. In the second it writes the returned byte to its target, or compares it with the key, and updates its registers. Memory and port reads return data in the cycle after the request. Copy and search use the full 16-bit count. Port streaming uses only the low byte of the count and leaves the high byte untouched. Because every count is decremented before it is tested for zero, a starting value of zero gives the largest possible block.

Top module: `blkmove_engine`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. It loads all registers from the `*_init` inputs and latches `cmd`. Here `cmd[1:0]` is 0 for copy, 1 for search, 2 for port-in and 3 for port-out; `cmd[2]`=1 moves pointers down (0 moves them up); `cmd[3]`=1 selects repeat. A `start` seen while busy is ignored.
- R2: One copy step reads the byte at `src_q`, writes it at `dst_q`, steps both pointers by one in the chosen direction, and decrements the 16-bit `cnt_q`.
- R3: A repeating copy continues until `cnt_q` becomes zero. A starting count of 0 moves 65536 bytes, and both pointers wrap modulo 2^16.
- R4: One search step reads the byte at `src_q`, compares it with the key, steps `src_q`, and decrements `cnt_q`. `match` is set to the result of the comparison.
- R5: A repeating search stops after the first step that either finds a match or brings `cnt_q` to zero.
- R6: Port-in reads the port `io_addr` and writes the byte to memory at `src_q`. Port-out reads memory at `src_q` and writes the byte to the port. Both step `src_q` and decrement only `cnt_q[7:0]`; `cnt_q[15:8]` and `dst_q` do not change.
- R7: A repeating port transfer continues while `cnt_q[7:0]` is nonzero after a step, so a starting low byte of 0 transfers 256 bytes.
- R8: A single-step command performs exactly one transfer or compare, then finishes, whatever the count.
- R9: A read request is issued in one cycle and its data is used in the next. Memory and port requests never fall in the same cycle.
- R10: `busy` is high from the cycle after `start` is accepted until the last step. `done` pulses for one cycle in the first idle cycle.
- R11: `cnt_nz` shows whether the active count is nonzero: all 16 bits for copy and search, the low byte for port transfers. `match` is cleared when a command is accepted.
- R12: After reset, all registers are zero, `busy`, `done`, `match` and `cnt_nz` are low, and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command when idle |
| cmd | input | 4 | Operation, direction, repeat |
| src_init | input | 16 | Initial source/memory pointer |
| dst_init | input | 16 | Initial destination pointer |
| cnt_init | input | 16 | Initial count |
| key_init | input | 8 | Search key |
| port_init | input | 8 | Port number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the read |
| io_req | output | 1 | Port access request |
| io_we | output | 1 | Port write (else read) |
| io_addr | output | 8 | Port number |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, one cycle after the read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_nz | output | 1 | Active count nonzero |
| match | output | 1 | Last compare found the key |
| src_q | output | 16 | Source/memory pointer |
| dst_q | output | 16 | Destination pointer |
| cnt_q | output | 16 | Count |

## Verification
In a repeating search, both stop reasons can arise in the same compare step: the count reaches zero exactly when the key is found. The bench provokes this by searching three bytes with the key placed in the third. The engine must stop exactly once, after three steps, with `match` high, `cnt_nz` low and `cnt_q` zero. The cycle-level model is compared with the design on every clock, and explicit end-of-command checks confirm the same values.

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int BW = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    cmd,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [DW-1:0] key_init,
  input  logic [PW-1:0] port_init,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          io_req,
  output logic          io_we,
  output logic [PW-1:0] io_addr,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  output logic          busy,
  output logic          done,
  output logic          cnt_nz,
  output logic          match,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q
);
  localparam logic [1:0] K_COPY = 2'd0, K_SRCH = 2'd1, K_IN = 2'd2, K_OUT = 2'd3;
  localparam logic [1:0] S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2;

  logic [1:0]    st, kind_r;
  logic          down_r, rep_r;
  logic [DW-1:0] key_r;
  logic [PW-1:0] port_r;

  wire          is_io   = kind_r[1];
  wire [AW-1:0] src_nxt = down_r ? src_q - AW'(1) : src_q + AW'(1);
  wire [AW-1:0] dst_nxt = down_r ? dst_q - AW'(1) : dst_q + AW'(1);
  wire [CW-1:0] cnt_nxt = is_io ? {cnt_q[CW-1:BW], cnt_q[BW-1:0] - BW'(1)} : cnt_q - CW'(1);
  wire          nz_nxt  = is_io ? |cnt_nxt[BW-1:0] : |cnt_nxt;
  wire          hit     = (mem_rdata == key_r);
  wire          stop    = !rep_r || !nz_nxt || (kind_r == K_SRCH && hit);

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_RD && kind_r != K_IN) ||
                     (st == S_WR && (kind_r == K_COPY || kind_r == K_IN));
  assign mem_we    = mem_req && (st == S_WR);
  assign mem_addr  = (st == S_WR && kind_r == K_COPY) ? dst_q : src_q;
  assign mem_wdata = (kind_r == K_IN) ? io_rdata : mem_rdata;
  assign io_req    = (st == S_RD && kind_r == K_IN) || (st == S_WR && kind_r == K_OUT);
  assign io_we     = io_req && (st == S_WR);
  assign io_addr   = port_r;
  assign io_wdata  = mem_rdata;
  assign cnt_nz    = is_io ? |cnt_q[BW-1:0] : |cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind_r <= K_COPY;
      down_r <= 1'b0;
      rep_r  <= 1'b0;
      key_r  <= '0;
      port_r <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      match  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          kind_r <= cmd[1:0];
          down_r <= cmd[2];
          rep_r  <= cmd[3];
          key_r  <= key_init;
          port_r <= port_init;
          src_q  <= src_init;
          dst_q  <= dst_init;
          cnt_q  <= cnt_init;
          match  <= 1'b0;
          st     <= S_RD;
        end
        S_RD: st <= S_WR;
        S_WR: begin
          src_q <= src_nxt;
          if (kind_r == K_COPY) dst_q <= dst_nxt;
          cnt_q <= cnt_nxt;
          if (kind_r == K_SRCH) match <= hit;
          if (stop) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module blkmove_engine_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    kind,
  input logic          busy,
  input logic          done,
  input logic          match,
  input logic          mem_req,
  input logic          mem_we,
  input logic          io_req,
  input logic [CW-1:0] cnt_q
);
  a_r9_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && io_req));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r11_match_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !match);
  a_r5_match_stops: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !match);
  a_r2_copy_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && kind == 2'd0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

bind blkmove_engine blkmove_engine_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .kind(kind_r), .busy(busy),
  .done(done), .match(match), .mem_req(mem_req), .mem_we(mem_we),
  .io_req(io_req), .cnt_q(cnt_q)
);

// File: tb/blkmove_engine_bench.sv
`timescale 1ns/1ps
module blkmove_engine_bench;
  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0]  cmd = 0;
  logic [15:0] src_init = 0, dst_init = 0, cnt_init = 0;
  logic [7:0]  key_init = 0, port_init = 0;
  logic        mem_req, mem_we, io_req, io_we, busy, done, cnt_nz, match;
  logic [15:0] mem_addr, src_q, dst_q, cnt_q;
  logic [7:0]  mem_wdata, io_addr, io_wdata;
  logic [7:0]  mem_rdata = 0, io_rdata = 0;

  blkmove_engine u_blkmove_engine (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, io_wr_cnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fill(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  logic [7:0] dmem [logic [15:0]];
  logic [7:0] rmem [logic [15:0]];
  function automatic logic [7:0] rd_dut(input logic [15:0] a);
    return dmem.exists(a) ? dmem[a] : fill(a);
  endfunction
  function automatic logic [7:0] rd_ref(input logic [15:0] a);
    return rmem.exists(a) ? rmem[a] : fill(a);
  endfunction

  logic [7:0] dev_idx = 0;
  always @(posedge clk) begin
    if (mem_req && mem_we) dmem[mem_addr] = mem_wdata;
    else if (mem_req) mem_rdata <= rd_dut(mem_addr);
    if (io_req && io_we) io_wr_cnt++;
    else if (io_req) begin
      io_rdata <= io_addr ^ dev_idx;
      dev_idx  <= dev_idx + 8'd1;
    end
  end

  // behavioural reference model
  int m_ph = 0;
  logic [1:0]  m_kind;
  bit          m_down, m_rep, m_match, m_done;
  logic [15:0] m_src, m_dst, m_cnt;
  logic [7:0]  m_key, m_port, m_dat, m_idx = 0;
  logic [15:0] wq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_kind = 0; m_down = 0; m_rep = 0; m_match = 0; m_done = 0;
      m_src = 0; m_dst = 0; m_cnt = 0; m_key = 0; m_port = 0;
    end else begin
      m_done = 0;
      if (m_ph == 0) begin
        if (start) begin
          m_kind = cmd[1:0]; m_down = cmd[2]; m_rep = cmd[3];
          m_src = src_init; m_dst = dst_init; m_cnt = cnt_init;
          m_key = key_init; m_port = port_init; m_match = 0; m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (m_kind == 2) begin m_dat = m_port ^ m_idx; m_idx++; end
        else m_dat = rd_ref(m_src);
        m_ph = 2;
      end else begin
        bit nz, stp;
        if (m_kind == 0) begin rmem[m_dst] = m_dat; wq.push_back(m_dst); end
        if (m_kind == 2) begin rmem[m_src] = m_dat; wq.push_back(m_src); end
        if (m_kind == 1) m_match = (m_dat == m_key);
        if (m_kind == 0) m_dst = m_down ? m_dst - 1 : m_dst + 1;
        m_src = m_down ? m_src - 1 : m_src + 1;
        if (m_kind[1]) begin m_cnt[7:0] = m_cnt[7:0] - 1; nz = (m_cnt[7:0] != 0); end
        else begin m_cnt = m_cnt - 1; nz = (m_cnt != 0); end
        stp = !m_rep || !nz || (m_kind == 1 && m_match);
        if (stp) begin m_ph = 0; m_done = 1; end else m_ph = 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    bit e_mreq, e_ireq, e_nz;
    string rt;
    rt = (m_kind == 0) ? "R2/R3" : (m_kind == 1) ? "R4/R5" : "R6/R7";
    e_mreq = (m_ph == 1 && m_kind != 2) || (m_ph == 2 && (m_kind == 0 || m_kind == 2));
    e_ireq = (m_ph == 1 && m_kind == 2) || (m_ph == 2 && m_kind == 3);
    e_nz   = m_kind[1] ? (m_cnt[7:0] != 0) : (m_cnt != 0);
    chk(busy == (m_ph != 0), "R10", "busy", busy, m_ph != 0);
    chk(done == m_done, "R10", "done", done, m_done);
    chk(cnt_nz == e_nz, "R11", "cnt_nz", cnt_nz, e_nz);
    chk(match == m_match, "R4/R5", "match", match, m_match);
    chk(src_q == m_src, rt, "src_q", src_q, m_src);
    chk(dst_q == m_dst, rt, "dst_q", dst_q, m_dst);
    chk(cnt_q == m_cnt, rt, "cnt_q", cnt_q, m_cnt);
    chk(mem_req == e_mreq, "R9", "mem_req", mem_req, e_mreq);
    chk(io_req == e_ireq, "R9", "io_req", io_req, e_ireq);
    if (mem_req && e_mreq) begin
      logic [15:0] ea;
      ea = (m_ph == 2 && m_kind == 0) ? m_dst : m_src;
      chk(mem_we == (m_ph == 2), "R9", "mem_we", mem_we, m_ph == 2);
      chk(mem_addr == ea, rt, "mem_addr", mem_addr, ea);
      if (m_ph == 2) chk(mem_wdata == m_dat, rt, "mem_wdata", mem_wdata, m_dat);
    end
    if (io_req && e_ireq) begin
      chk(io_we == (m_ph == 2), "R9", "io_we", io_we, m_ph == 2);
      chk(io_addr == m_port, "R6", "io_addr", io_addr, m_port);
      if (m_ph == 2) chk(io_wdata == m_dat, "R6", "io_wdata", io_wdata, m_dat);
    end
  end

  task automatic run_op(input logic [3:0] c, input logic [15:0] s, input logic [15:0] d,
                        input logic [15:0] n, input logic [7:0] k, input logic [7:0] p,
                        input bit inject, input string tag);
    @(negedge clk);
    cmd = c; src_init = s; dst_init = d; cnt_init = n; key_init = k; port_init = p;
    start = 1;
    @(negedge clk);
    start = 0;
    if (inject) begin
      repeat (3) @(negedge clk);
      cmd = 4'b1001; src_init = 16'hAAAA; cnt_init = 16'h0055;
      start = 1;  // R1: ignored while busy
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    while (wq.size() > 0) begin
      logic [15:0] a;
      a = wq.pop_front();
      chk(rd_dut(a) == rd_ref(a), tag, "memory byte", rd_dut(a), rd_ref(a));
    end
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !match && !cnt_nz, "R12", "reset flags",
        {busy, done, match, cnt_nz}, 0);
    chk(src_q == 0 && dst_q == 0 && cnt_q == 0, "R12", "reset regs", cnt_q, 0);
    chk(!mem_req && !io_req, "R12", "reset requests", {mem_req, io_req}, 0);

    run_op(4'b0000, 16'h0100, 16'h0400, 16'd5, 8'h00, 8'h00, 0, "R8");
    chk(cnt_q == 16'd4 && src_q == 16'h0101 && dst_q == 16'h0401, "R8", "single copy cnt", cnt_q, 4);
    chk(rd_dut(16'h0400) == 8'h3D, "R2", "copied byte", rd_dut(16'h0400), 8'h3D);

    run_op(4'b0000, 16'h0110, 16'h0410, 16'd0, 8'h00, 8'h00, 0, "R8");
    chk(cnt_q == 16'hFFFF, "R8", "single copy from zero count", cnt_q, 16'hFFFF);

    run_op(4'b1000, 16'h0120, 16'h0420, 16'd4, 8'h00, 8'h00, 0, "R3");
    chk(cnt_q == 0 && src_q == 16'h0124 && dst_q == 16'h0424, "R3", "repeat copy up", src_q, 16'h0124);

    run_op(4'b1100, 16'h0135, 16'h0435, 16'd3, 8'h00, 8'h00, 1, "R1");
    chk(src_q == 16'h0132 && dst_q == 16'h0432 && cnt_q == 0, "R1", "copy down with ignored start", src_q, 16'h0132);
    chk(rd_dut(16'h0433) == 8'h0E, "R2", "copy down byte", rd_dut(16'h0433), 8'h0E);

    run_op(4'b1001, 16'h0200, 16'h1111, 16'd10, 8'h3C, 8'h00, 0, "R5");
    chk(match && src_q == 16'h0203 && cnt_q == 16'd7, "R5", "early stop on match", cnt_q, 7);

    run_op(4'b1001, 16'h0200, 16'h1111, 16'd3, 8'h3C, 8'h00, 0, "R5");
    chk(match && !cnt_nz && cnt_q == 0, "R5", "match and zero together", cnt_q, 0);

    run_op(4'b1101, 16'h0300, 16'h1111, 16'd4, 8'hFF, 8'h00, 0, "R4");
    chk(!match && src_q == 16'h02FC && cnt_q == 0, "R4", "search down no match", src_q, 16'h02FC);

    run_op(4'b0001, 16'h0201, 16'h1111, 16'd9, 8'h3F, 8'h00, 0, "R8");
    chk(match && cnt_q == 16'd8 && cnt_nz, "R8", "single search", cnt_q, 8);

    run_op(4'b1010, 16'h5000, 16'h7777, 16'hAB03, 8'h00, 8'h40, 0, "R6");
    chk(src_q == 16'h5003 && cnt_q == 16'hAB00 && dst_q == 16'h7777, "R6", "port in", cnt_q, 16'hAB00);

    w0 = io_wr_cnt;
    run_op(4'b1111, 16'h6000, 16'h7777, 16'h1200, 8'h00, 8'h41, 0, "R7");
    chk(io_wr_cnt - w0 == 256, "R7", "port writes from zero count", io_wr_cnt - w0, 256);
    chk(cnt_q == 16'h1200 && src_q == 16'h5F00, "R7", "port out final", cnt_q, 16'h1200);

    run_op(4'b1000, 16'h1000, 16'h9000, 16'd0, 8'h00, 8'h00, 0, "R3");
    chk(cnt_q == 0 && src_q == 16'h1000 && dst_q == 16'h9000, "R3", "65536-byte copy", dst_q, 16'h9000);
    chk(rd_dut(16'h9005) == 8'h29, "R3", "wrapped copy byte", rd_dut(16'h9005), 8'h29);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog act=%0d exp=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule